// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Unit

This unit sits beside a serial peripheral controller. It takes twelve live condition flags: transfer finished, transfer able to accept a command, receive and transmit queue thresholds, queue empty and full, and queue overrun and underrun. It turns them into sticky interrupt causes. The flags are registered into a status vector that software can read. A cause bit latches only when its status bit goes from 0 to 1. It never latches on the level, so a driver must read the live status before it starts to wait for an interrupt. Software clears causes by writing ones, selects which causes may interrupt through an enable mask, and sees a single registered interrupt line.

Access is through a small register port. A request with a write strobe updates a register. A request without the strobe returns registered read data, with a valid pulse, one cycle later. The queues and the shift engine sit outside the unit, and their flags arrive as plain inputs.

Top module: `irq_cause_unit`

## Requirements
- R1: A read of address 0 returns the status vector with these bit positions: 0 transfer done, 1 transfer ready, 2 receive queue ready, 3 transmit queue ready, 4 receive queue empty, 5 receive queue full, 6 transmit queue empty, 7 transmit queue full, 8 receive underrun, 9 receive overrun, 10 transmit underrun, 11 transmit overrun.
- R2: The status vector equals the flag inputs delayed by one register stage. Writes to address 0 have no effect.
- R3: A cause bit (read at address 1) is set only on a 0-to-1 change of its status bit. A status bit that stays high, or falls, sets nothing.
- R4: A write to address 1 clears every cause bit written as 1 and leaves the others unchanged. Writing all ones clears all causes.
- R5: When a rising edge and a clear of the same cause bit fall in the same cycle, the bit ends set.
- R6: Address 2 holds the enable mask, which can be written and read back. A mask of zero keeps the interrupt low whatever causes are pending.
- R7: irq_o is a register. It rises one cycle after some cause bit and its mask bit are both 1. It falls one cycle after the last enabled cause is cleared or masked.
- R8: Reset (rst_ni low) clears status, causes, mask, irq_o and rvalid_o.
- R9: A read request returns rdata_o with rvalid_o high in the following cycle. Address 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 12 | Live condition flags, same bit order as the status vector |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write strobe for the request |
| addr_i | input | 2 | Register address: 0 status, 1 cause, 2 mask, 3 reserved |
| wdata_i | input | 12 | Write data |
| rdata_o | output | 12 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Interrupt, registered |

## Verification
A software clear of a cause bit and a fresh rising edge on that bit's flag can land in the same clock cycle. The bench provokes this by raising a flag and then issuing the clear write one cycle later, so that the write is sampled on the same edge that latches the new cause. The clear also covers a second, older cause bit. Judging the readback then shows both halves in one result: the older bit is gone, and the newly latched bit survives.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC = 12;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  // status bit positions (software decodes these)
  localparam int unsigned B_XFER_DONE = 0;
  localparam int unsigned B_XFER_RDY  = 1;
  localparam int unsigned B_RXQ_RDY   = 2;
  localparam int unsigned B_TXQ_RDY   = 3;
  localparam int unsigned B_RXQ_EMPTY = 4;
  localparam int unsigned B_RXQ_FULL  = 5;
  localparam int unsigned B_TXQ_EMPTY = 6;
  localparam int unsigned B_TXQ_FULL  = 7;
  localparam int unsigned B_RXQ_UNDER = 8;
  localparam int unsigned B_RXQ_OVER  = 9;
  localparam int unsigned B_TXQ_UNDER = 10;
  localparam int unsigned B_TXQ_OVER  = 11;
endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] stat_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      stat_q <= flags_i;
      prev_q <= stat_q;
    end
  end

  assign status_o = stat_q;
  assign rise_o   = stat_q & ~prev_q;

  // R2: status tracks inputs one cycle late
  a_r2_status_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (status_o == $past(flags_i)))
    else $error("a_r2_status_lag");

  // R3: a rise is only reported after the bit was low
  a_r3_rise_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((rise_o & $past(status_o)) == '0))
    else $error("a_r3_rise_from_low");
endmodule

// File: rtl/irqc_cause_bank.sv
module irqc_cause_bank #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cause_o
);
  for (genvar g = 0; g < W; g++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bit_q <= 1'b0;
      else if (rise_i[g]) bit_q <= 1'b1;   // set beats clear
      else if (clr_i[g])  bit_q <= 1'b0;
    end
    assign cause_o[g] = bit_q;
  end

  // R3: every rise latches
  a_r3_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((cause_o & $past(rise_i)) == $past(rise_i)))
    else $error("a_r3_rise_sets");

  // R3: no cause appears without a rise
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((cause_o & ~$past(cause_o) & ~$past(rise_i)) == '0))
    else $error("a_r3_no_spurious");

  // R4: clear without a concurrent rise empties the bit
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~rise_i) != '0) |=> ((cause_o & $past(clr_i & ~rise_i)) == '0))
    else $error("a_r4_clear");

  // R5: set wins on collision
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & rise_i) != '0) |=> ((cause_o & $past(clr_i & rise_i)) == $past(clr_i & rise_i)))
    else $error("a_r5_set_wins");
endmodule

// File: rtl/irqc_regport.sv
module irqc_regport
  import irqc_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      status_i,
  input  logic [W-1:0]      cause_i,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      rdata_o,
  output logic              rvalid_o
);
  reg_sel_e     sel;
  logic         wr, rd;
  logic [W-1:0] mask_q, rdata_q, rd_mux;
  logic         rvalid_q;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = req_i &  we_i;
  assign rd  = req_i & ~we_i;

  assign clr_o = (wr && sel == SEL_CAUSE) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_mux = status_i;
      SEL_CAUSE:  rd_mux = cause_i;
      SEL_MASK:   rd_mux = mask_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (wr && sel == SEL_MASK) mask_q <= wdata_i;
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign mask_o   = mask_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R9: read answered next cycle, writes answered never
  a_r9_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (rvalid_o == ($past(req_i) && !$past(we_i))))
    else $error("a_r9_rvalid");

  // R6: mask only moves on a mask write
  a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == SEL_MASK) |=> $stable(mask_o))
    else $error("a_r6_mask_hold");
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irqc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               rvalid_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] status, rise, cause, mask, clr;
  logic               irq_q;

  irqc_edge_detect #(.W(NUM_SRC)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags_i),
    .status_o (status),
    .rise_o   (rise)
  );

  irqc_cause_bank #(.W(NUM_SRC)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .clr_i   (clr),
    .cause_o (cause)
  );

  irqc_regport #(.W(NUM_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .cause_i  (cause),
    .mask_o   (mask),
    .clr_o    (clr),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(cause & mask);
  end
  assign irq_o = irq_q;

  // R7: line follows enabled causes by one cycle
  a_r7_irq_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (irq_o == ($past(cause & mask) != '0)))
    else $error("a_r7_irq_follow");

  // R6: zero mask keeps the line low
  a_r6_mask_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |=> !irq_o)
    else $error("a_r6_mask_zero");
endmodule

// File: tb/sim_irq_cause_unit.sv
`timescale 1ns/1ps
module sim_irq_cause_unit;
  import irqc_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] flags = '0;
  logic               req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [NUM_SRC-1:0] wdata = '0;
  logic [NUM_SRC-1:0] rdata;
  logic               rvalid, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NUM_SRC-1:0] exp;
    string              tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_cause_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .flags_i(flags), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  // monitor: pops expectations as read data comes back
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected read data actual=%h expected=none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_read(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] e,
                             input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [NUM_SRC-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL all watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R8 reset state
    check_irq(1'b0, "R8 reset");
    expect_read(SEL_STATUS, 12'h000, "R8 status after reset");
    expect_read(SEL_CAUSE,  12'h000, "R8 cause after reset");
    expect_read(SEL_MASK,   12'h000, "R8 mask after reset");
    expect_read(SEL_RSVD,   12'h000, "R9 reserved reads zero");

    // R2 one-stage lag, R1 layout (done=bit0, rx ready=bit2)
    flags = 12'h005;
    expect_read(SEL_STATUS, 12'h000, "R2 status not yet updated");
    expect_read(SEL_STATUS, 12'h005, "R1 status bits 0 and 2");
    expect_read(SEL_CAUSE,  12'h005, "R3 rising edges latched");
    reg_write(SEL_STATUS, 12'hFFF);
    expect_read(SEL_STATUS, 12'h005, "R2 status write ignored");

    // R4 clear all; R3 held level does not re-set
    reg_write(SEL_CAUSE, 12'hFFF);
    tick(3);
    expect_read(SEL_CAUSE, 12'h000, "R3 level does not re-set / R4 clear all");

    // R4 selective clear on bits 4..7
    flags = 12'h0F5;
    tick(3);
    expect_read(SEL_CAUSE, 12'h0F0, "R3 queue empty/full edges");
    reg_write(SEL_CAUSE, 12'h030);
    expect_read(SEL_CAUSE, 12'h0C0, "R4 selective clear");

    // R6 zero mask
    tick(2);
    check_irq(1'b0, "R6 mask zero blocks");

    // R7 enable bit 6
    reg_write(SEL_MASK, 12'h040);
    check_irq(1'b0, "R7 registered rise delay");
    tick(1);
    check_irq(1'b1, "R7 irq asserted");
    expect_read(SEL_MASK, 12'h040, "R6 mask readback");

    // R7 clear last enabled cause
    reg_write(SEL_CAUSE, 12'h040);
    check_irq(1'b1, "R7 irq held one cycle after clear");
    tick(1);
    check_irq(1'b0, "R7 irq deasserts after clear");

    // R7 masking a pending cause (bit 7 still pending)
    reg_write(SEL_MASK, 12'h080);
    tick(1);
    check_irq(1'b1, "R7 irq from bit 7");
    reg_write(SEL_MASK, 12'h000);
    check_irq(1'b1, "R7 irq held one cycle after mask");
    tick(1);
    check_irq(1'b0, "R7 irq deasserts after mask");

    // R5 collision: clear lands on the edge that latches bit 8
    reg_write(SEL_CAUSE, 12'hFFF);
    flags = 12'h0F7;
    tick(3);
    expect_read(SEL_CAUSE, 12'h002, "R3 transfer ready edge");
    flags = 12'h1F7;
    tick(1);
    reg_write(SEL_CAUSE, 12'h102);
    expect_read(SEL_CAUSE, 12'h100, "R5 set wins over clear");

    // R1/R3 overrun/underrun bits 9..11
    reg_write(SEL_CAUSE, 12'hFFF);
    flags = 12'hFF7;
    tick(3);
    expect_read(SEL_CAUSE,  12'hE00, "R3 upper bits latch");
    expect_read(SEL_STATUS, 12'hFF7, "R1 status upper bits");

    // R3 falling edges set nothing
    flags = 12'h000;
    tick(3);
    expect_read(SEL_CAUSE, 12'hE00, "R3 falling edges ignored");

    // R9 reserved address ignores writes
    reg_write(SEL_RSVD, 12'hABC);
    expect_read(SEL_RSVD, 12'h000, "R9 reserved write ignored");

    // R8 reset mid-run
    reg_write(SEL_MASK, 12'hFFF);
    tick(1);
    check_irq(1'b1, "R7 irq before reset");
    tick(1);
    rst_n = 1'b0;
    tick(2);
    check_irq(1'b0, "R8 irq cleared by reset");
    rst_n = 1'b1;
    expect_read(SEL_MASK,  12'h000, "R8 mask cleared by reset");
    expect_read(SEL_CAUSE, 12'h000, "R8 cause cleared by reset");
    tick(3);

    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 pending reads actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule